// File: doc/BRIEF.md
# Protected Region Write Snooper

This block sits beside the link between the system interconnect and main memory and watches the write address channel of that link without taking part in it. The block produces no ready signal and drives nothing onto the bus. It only samples a write request on a cycle where valid and ready are both high. Requests from processors, DMA engines and any other master are treated the same way. Each sampled burst is converted to the byte span it covers. That span is compared against a small set of protected physical ranges. A single byte of overlap is a violation.

The ranges fall into two groups. Boot regions hold immutable areas such as kernel code. Firmware writes them through a configuration port, then seals that port, and it stays sealed until reset. Runtime regions follow data that moves, such as the page-directory entries that map kernel code. These regions change only through a report port, and only when a report arrives flagged as authenticated by the logic in front of this block. On the first violation the block raises a sticky interrupt and captures the offending start address and master ID.

Two small state machines run the block. The seal machine has the states LK_OPEN and LK_SEALED. It moves from LK_OPEN to LK_SEALED on `cfg_lock`, and only a reset takes it back. The alarm machine has the states AL_QUIET and AL_TRIPPED. It moves from AL_QUIET to AL_TRIPPED on a sampled write that overlaps a region, and only a reset takes it back.

Top module: `prot_write_snooper`

## Requirements
- R1: After reset, `irq` is 0, `viol_addr` and `viol_id` are 0, the configuration port is open, and every region is empty. A region is empty whenever its base is greater than its limit, and reset sets base to all ones and limit to 0. With all regions empty, no write is flagged.
- R2: A sampled write whose byte span overlaps an active region, even by one byte at either end, sets `irq` to 1 on the output after the clock edge that sampled it.
- R3: A write whose span ends at base−1 or starts at limit+1 of every active region leaves `irq` at 0. Region bounds are inclusive.
- R4: A write request is examined only on a cycle where `aw_valid` and `aw_ready` are both 1. A request held with `aw_ready` at 0 never raises `irq`.
- R5: Once set, `irq` stays at 1 until reset.
- R6: `viol_addr` and `viol_id` capture the start address and ID of the first violating write, and later violations do not change them.
- R7: Boot regions (indices 0 to NUM_BOOT−1) are written from `cfg_*` when `cfg_we` is 1, but only while the port is open. A `cfg_lock` pulse seals the port until reset, and writes after that have no effect. A write in the same cycle as the lock pulse still lands.
- R8: Runtime regions (indices NUM_BOOT and up) change only when `rpt_valid` and `rpt_auth` are both 1 on the same cycle. Reports without `rpt_auth` are ignored. Reports aimed at boot indices are ignored, and so are `cfg_*` writes aimed at runtime indices.
- R9: A burst covers (aw_len+1)·2^aw_size bytes starting at `aw_addr`. It overlaps a region exactly when its first byte is at or below the limit and its last byte is at or above the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_valid | input | 1 | Snooped write address valid |
| aw_ready | input | 1 | Snooped write address ready |
| aw_addr | input | ADDR_W | Snooped burst start address |
| aw_len | input | LEN_W | Snooped beats minus one |
| aw_size | input | 3 | Snooped log2 bytes per beat |
| aw_id | input | ID_W | Snooped master ID |
| cfg_we | input | 1 | Boot region write strobe |
| cfg_idx | input | IDX_W | Region index for configuration |
| cfg_base | input | ADDR_W | Inclusive lower bound |
| cfg_limit | input | ADDR_W | Inclusive upper bound |
| cfg_lock | input | 1 | Seals the configuration port |
| rpt_valid | input | 1 | Runtime report present |
| rpt_auth | input | 1 | Report passed authentication |
| rpt_idx | input | IDX_W | Region index for the report |
| rpt_base | input | ADDR_W | Reported inclusive lower bound |
| rpt_limit | input | ADDR_W | Reported inclusive upper bound |
| irq | output | 1 | Sticky violation interrupt |
| viol_addr | output | ADDR_W | Start address of first violation |
| viol_id | output | ID_W | Master ID of first violation |

## Verification
The region registers and the seal state have no direct output, so their faults show up at the ports only through `irq`. A region that was wrongly written, or one that missed a legitimate update, becomes visible at the first sampled write near its bounds. The interrupt then appears, or fails to appear, one edge after the handshake. A bad alarm state shows as `irq` dropping, or as the captured address and ID moving, on the very next cycle. For that reason the outputs are compared against a behavioural model on every clock. The bench also places writes exactly at the inclusive edges, so that off-by-one errors in the span arithmetic change `irq`.

// File: rtl/prw_pkg.sv
package prw_pkg;
    typedef enum logic {LK_OPEN = 1'b0, LK_SEALED = 1'b1} seal_state_t;
    typedef enum logic {AL_QUIET = 1'b0, AL_TRIPPED = 1'b1} alarm_state_t;
endpackage

// File: rtl/prw_region_bank.sv
module prw_region_bank
    import prw_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_BOOT = 2,
    parameter int NUM_RT   = 2,
    parameter int IDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic              cfg_lock,
    input  logic              rpt_valid,
    input  logic              rpt_auth,
    input  logic [IDX_W-1:0]  rpt_idx,
    input  logic [ADDR_W-1:0] rpt_base,
    input  logic [ADDR_W-1:0] rpt_limit,
    output logic [ADDR_W-1:0] base_o  [NUM_BOOT+NUM_RT],
    output logic [ADDR_W-1:0] limit_o [NUM_BOOT+NUM_RT]
);
    localparam int NUM_REG = NUM_BOOT + NUM_RT;

    seal_state_t state_q, state_d;
    logic        open_w;
    logic        rpt_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (cfg_lock) state_d = LK_SEALED;
            LK_SEALED: state_d = LK_SEALED;
            default:   state_d = LK_OPEN;
        endcase
    end

    always_comb begin
        open_w = (state_q == LK_OPEN);
        rpt_ok = rpt_valid && rpt_auth;
    end

    AST_SEAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == LK_SEALED |=> state_q == LK_SEALED);  // R7

    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
        logic wr_en;
        logic [ADDR_W-1:0] wr_base, wr_limit;
        if (g < NUM_BOOT) begin : g_boot
            always_comb begin
                wr_en    = open_w && cfg_we && (cfg_idx == IDX_W'(g));
                wr_base  = cfg_base;
                wr_limit = cfg_limit;
            end
            AST_BOOT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
                state_q == LK_SEALED |=> $stable(base_o[g]) && $stable(limit_o[g]));  // R7
        end else begin : g_rt
            always_comb begin
                wr_en    = rpt_ok && (rpt_idx == IDX_W'(g));
                wr_base  = rpt_base;
                wr_limit = rpt_limit;
            end
            AST_RT_REPORT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                !(rpt_valid && rpt_auth && rpt_idx == IDX_W'(g))
                |=> $stable(base_o[g]) && $stable(limit_o[g]));  // R8
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_o[g]  <= '1;
                limit_o[g] <= '0;
            end else if (wr_en) begin
                base_o[g]  <= wr_base;
                limit_o[g] <= wr_limit;
            end
        end
    end
endmodule

// File: rtl/prw_overlap.sv
module prw_overlap #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 8,
    parameter int NUM_REG = 4
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  beats_m1,
    input  logic [2:0]        beat_size,
    input  logic [ADDR_W-1:0] base_i  [NUM_REG],
    input  logic [ADDR_W-1:0] limit_i [NUM_REG],
    output logic              hit
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0]   first_b, last_b, span_b;
    logic [NUM_REG-1:0] hit_vec;

    always_comb begin
        span_b  = (EXT_W'(beats_m1) + EXT_W'(1)) << beat_size;
        first_b = EXT_W'(start_addr);
        last_b  = first_b + span_b - EXT_W'(1);
    end

    for (genvar g = 0; g < NUM_REG; g++) begin : g_cmp
        always_comb begin
            hit_vec[g] = (base_i[g] <= limit_i[g])
                      && (first_b <= EXT_W'(limit_i[g]))
                      && (last_b  >= EXT_W'(base_i[g]));
        end
    end

    always_comb hit = |hit_vec;
endmodule

// File: rtl/prw_alarm.sv
module prw_alarm
    import prw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs,
    input  logic              hit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ID_W-1:0]   id,
    output logic              irq,
    output logic [ADDR_W-1:0] viol_addr,
    output logic [ID_W-1:0]   viol_id
);
    alarm_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AL_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AL_QUIET:   if (hs && hit) state_d = AL_TRIPPED;
            AL_TRIPPED: state_d = AL_TRIPPED;
            default:    state_d = AL_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_addr <= '0;
            viol_id   <= '0;
        end else if (state_q == AL_QUIET && state_d == AL_TRIPPED) begin
            viol_addr <= addr;
            viol_id   <= id;
        end
    end

    always_comb irq = (state_q == AL_TRIPPED);

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> irq);  // R5
    AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> $stable(viol_addr) && $stable(viol_id));  // R6
    AST_HIT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        hs && hit |=> irq);  // R2
    AST_QUIET_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
        !hs && !irq |=> !irq);  // R4
endmodule

// File: rtl/prot_write_snooper.sv
module prot_write_snooper #(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 8,
    parameter int ID_W     = 4,
    parameter int NUM_BOOT = 2,
    parameter int NUM_RT   = 2,
    parameter int IDX_W    = ((NUM_BOOT + NUM_RT) > 1) ? $clog2(NUM_BOOT + NUM_RT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aw_valid,
    input  logic              aw_ready,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic [2:0]        aw_size,
    input  logic [ID_W-1:0]   aw_id,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic              cfg_lock,
    input  logic              rpt_valid,
    input  logic              rpt_auth,
    input  logic [IDX_W-1:0]  rpt_idx,
    input  logic [ADDR_W-1:0] rpt_base,
    input  logic [ADDR_W-1:0] rpt_limit,
    output logic              irq,
    output logic [ADDR_W-1:0] viol_addr,
    output logic [ID_W-1:0]   viol_id
);
    localparam int NUM_REG = NUM_BOOT + NUM_RT;

    logic [ADDR_W-1:0] base_w  [NUM_REG];
    logic [ADDR_W-1:0] limit_w [NUM_REG];
    logic              hit_w;
    logic              hs_w;

    always_comb hs_w = aw_valid && aw_ready;

    prw_region_bank #(
        .ADDR_W(ADDR_W), .NUM_BOOT(NUM_BOOT), .NUM_RT(NUM_RT), .IDX_W(IDX_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
        .cfg_limit(cfg_limit), .cfg_lock(cfg_lock),
        .rpt_valid(rpt_valid), .rpt_auth(rpt_auth), .rpt_idx(rpt_idx),
        .rpt_base(rpt_base), .rpt_limit(rpt_limit),
        .base_o(base_w), .limit_o(limit_w)
    );

    prw_overlap #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NUM_REG(NUM_REG)
    ) u_cmp (
        .start_addr(aw_addr), .beats_m1(aw_len), .beat_size(aw_size),
        .base_i(base_w), .limit_i(limit_w), .hit(hit_w)
    );

    prw_alarm #(
        .ADDR_W(ADDR_W), .ID_W(ID_W)
    ) u_alarm (
        .clk(clk), .rst_n(rst_n), .hs(hs_w), .hit(hit_w),
        .addr(aw_addr), .id(aw_id),
        .irq(irq), .viol_addr(viol_addr), .viol_id(viol_id)
    );
endmodule

// File: tb/prot_write_snooper_bench.sv
module prot_write_snooper_bench;
    localparam int CLK_P = 10;
    localparam int NB = 2;
    localparam int NR = 4;

    logic clk = 0, rst_n = 0;
    logic aw_valid = 0, aw_ready = 0;
    logic [31:0] aw_addr = 0;
    logic [7:0] aw_len = 0;
    logic [2:0] aw_size = 0;
    logic [3:0] aw_id = 0;
    logic cfg_we = 0, cfg_lock = 0, rpt_valid = 0, rpt_auth = 0;
    logic [1:0] cfg_idx = 0, rpt_idx = 0;
    logic [31:0] cfg_base = 0, cfg_limit = 0, rpt_base = 0, rpt_limit = 0;
    logic irq;
    logic [31:0] viol_addr;
    logic [3:0] viol_id;

    int checks = 0, failures = 0;
    bit done = 0;

    longint m_base [NR];
    longint m_lim [NR];
    bit m_locked = 0, m_irq = 0;
    longint m_va = 0;
    int m_vid = 0;

    always #(CLK_P/2) clk = ~clk;

    prot_write_snooper u_prot_write_snooper (
        .clk(clk), .rst_n(rst_n), .aw_valid(aw_valid), .aw_ready(aw_ready),
        .aw_addr(aw_addr), .aw_len(aw_len), .aw_size(aw_size), .aw_id(aw_id),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
        .cfg_lock(cfg_lock), .rpt_valid(rpt_valid), .rpt_auth(rpt_auth),
        .rpt_idx(rpt_idx), .rpt_base(rpt_base), .rpt_limit(rpt_limit),
        .irq(irq), .viol_addr(viol_addr), .viol_id(viol_id));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // reference model, behavioural
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) begin m_base[i] = 64'hFFFF_FFFF; m_lim[i] = 0; end
            m_locked = 0; m_irq = 0; m_va = 0; m_vid = 0;
        end else begin
            if (aw_valid && aw_ready && !m_irq) begin
                longint s, e;
                bit h;
                s = longint'(aw_addr);
                e = s + ((longint'(aw_len) + 1) << aw_size) - 1;
                h = 0;
                for (int i = 0; i < NR; i++)
                    if (m_base[i] <= m_lim[i] && s <= m_lim[i] && e >= m_base[i]) h = 1;
                if (h) begin m_irq = 1; m_va = s; m_vid = aw_id; end
            end
            if (cfg_we && !m_locked && cfg_idx < NB) begin
                m_base[cfg_idx] = cfg_base; m_lim[cfg_idx] = cfg_limit;
            end
            if (rpt_valid && rpt_auth && rpt_idx >= NB) begin
                m_base[rpt_idx] = rpt_base; m_lim[rpt_idx] = rpt_limit;
            end
            if (cfg_lock) m_locked = 1;
        end
    end

    // every-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq == m_irq, "R2 R5 irq vs model", irq, m_irq);
            chk(viol_addr == m_va[31:0], "R6 viol_addr vs model", viol_addr, m_va);
            chk(viol_id == m_vid[3:0], "R6 viol_id vs model", viol_id, m_vid);
        end
    end

    task automatic aw(input logic [31:0] a, input int len, input int sz, input int id, input bit rdy);
        @(negedge clk);
        aw_valid = 1; aw_ready = rdy; aw_addr = a;
        aw_len = 8'(len); aw_size = 3'(sz); aw_id = 4'(id);
        @(negedge clk);
        aw_valid = 0; aw_ready = 0;
    endtask

    task automatic cfg(input int idx, input logic [31:0] b, input logic [31:0] l);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 2'(idx); cfg_base = b; cfg_limit = l;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic lock();
        @(negedge clk); cfg_lock = 1;
        @(negedge clk); cfg_lock = 0;
    endtask

    task automatic rpt(input int idx, input bit auth, input logic [31:0] b, input logic [31:0] l);
        @(negedge clk);
        rpt_valid = 1; rpt_auth = auth; rpt_idx = 2'(idx); rpt_base = b; rpt_limit = l;
        @(negedge clk);
        rpt_valid = 0; rpt_auth = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
    endtask

    initial begin
        #(CLK_P * 200000);
        failures++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(irq == 0, "R1 irq after reset", irq, 0);
        chk(viol_addr == 0 && viol_id == 0, "R1 captured fields after reset", viol_addr, 0);
        aw(32'h0000_1000, 15, 3, 1, 1);
        chk(irq == 0, "R1 empty regions flag nothing", irq, 0);

        cfg(0, 32'h0000_1000, 32'h0000_1FFF);
        cfg(1, 32'h0000_8000, 32'h0000_80FF);
        cfg(2, 32'h0000_5000, 32'h0000_50FF);   // runtime index via cfg: ignored
        aw(32'h0000_5000, 0, 2, 2, 1);
        chk(irq == 0, "R8 cfg write to runtime index ignored", irq, 0);
        aw(32'h0000_0FF0, 3, 2, 2, 1);            // ends at 0x0FFF
        chk(irq == 0, "R3 span ending at base-1", irq, 0);
        aw(32'h0000_2000, 7, 3, 2, 1);
        chk(irq == 0, "R3 span starting at limit+1", irq, 0);
        aw(32'h0000_1000, 0, 2, 3, 0);
        aw(32'h0000_8010, 1, 2, 3, 0);
        chk(irq == 0, "R4 request without ready ignored", irq, 0);

        lock();
        cfg(0, 32'h0000_0000, 32'h0000_00FF);
        aw(32'h0000_0040, 0, 2, 4, 1);
        chk(irq == 0, "R7 sealed boot region not rewritten", irq, 0);

        rpt(2, 0, 32'h0000_4000, 32'h0000_403F);
        aw(32'h0000_4000, 0, 2, 4, 1);
        chk(irq == 0, "R8 unauthenticated report ignored", irq, 0);
        rpt(0, 1, 32'h0000_0000, 32'h0000_00FF);
        aw(32'h0000_0010, 0, 2, 4, 1);
        chk(irq == 0, "R8 report to boot index ignored", irq, 0);

        rpt(2, 1, 32'h0000_4000, 32'h0000_403F);
        aw(32'h0000_3FF0, 0, 4, 5, 1);            // 16 bytes, ends 0x3FFF
        chk(irq == 0, "R9 one beat stops short of base", irq, 0);
        aw(32'h0000_3FF0, 1, 4, 5, 1);            // 32 bytes, ends 0x400F
        chk(irq == 1, "R2 burst tail overlaps runtime region", irq, 1);
        chk(viol_addr == 32'h0000_3FF0, "R6 captured address", viol_addr, 32'h3FF0);
        chk(viol_id == 4'd5, "R6 captured id", viol_id, 5);
        aw(32'h0000_1800, 0, 2, 9, 1);
        chk(viol_addr == 32'h0000_3FF0 && viol_id == 4'd5, "R6 second violation not captured",
            viol_addr, 32'h3FF0);
        repeat (5) @(negedge clk);
        chk(irq == 1, "R5 irq held", irq, 1);

        do_reset();
        @(negedge clk);
        chk(irq == 0, "R1 irq cleared by reset", irq, 0);
        cfg(0, 32'h0000_1000, 32'h0000_1FFF);
        lock();
        aw(32'h0000_1FFF, 0, 0, 6, 1);
        chk(irq == 1, "R2 single byte at limit", irq, 1);
        chk(viol_addr == 32'h0000_1FFF, "R7 open port accepted write after reset", viol_addr, 32'h1FFF);

        do_reset();
        cfg(1, 32'h0000_1000, 32'h0000_10FF);
        aw(32'h0000_0FFD, 3, 0, 7, 1);            // bytes 0x0FFD..0x1000
        chk(irq == 1, "R9 last byte touches base", irq, 1);

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule